// File: doc/BRIEF.md
# Ping-Pong Receive Buffer for a USB OUT Endpoint

This block holds the data of OUT packets that a USB device endpoint receives, until the CPU reads them. It runs with one bank or with two banks used in turn. On the packet side, a byte stream enters through a valid/ready port. A packet-end strobe, qualified by a bad-packet flag, closes each packet. The block answers every good packet with a one-cycle ACK or NAK pulse. The answer depends only on whether the bank being filled was free when the packet began.

On the CPU side there are plain control and status pins. A received flag is set when the current bank holds a fresh packet. It drives an interrupt through an enable pin. A bank-owned status shows that the CPU holds the current bank, and a read-allowed status shows that unread bytes remain. A count gives the bytes still unread, and a valid/ready output stream pops one byte per accepted transfer.

The CPU first clears the received flag and then releases the bank. The release hands the current bank back to the packet side and moves on to the next bank. In two-bank mode, if the host has already filled the next bank, the received flag rises again at once.

Back-pressure rules: `in_ready` is low while the fill bank is owned by the CPU or already holds the maximum byte count. A byte offered while `in_ready` is low is dropped and not stored, because USB cannot stall mid-packet. Such a packet is later answered with NAK if the bank was owned. On the read stream, `rd_valid` equals the read-allowed status. A pop with `rd_valid` low has no effect and `rd_data` reads zero.

Top module: `rx_pingpong_buf`

## Requirements
- R1: After reset, both banks are empty, `rx_flag`, `bank_owned`, `rd_valid`, `irq`, `hs_ack` and `hs_nak` are 0, `byte_cnt` is 0, `in_ready` is 1, and the first packet goes to bank 0.
- R2: A good packet end (`pkt_end`=1, `pkt_bad`=0) whose fill bank is free commits the packet. One cycle later, `hs_ack` pulses for one cycle. If the committed bank is the current bank, `rx_flag` is 1 and `irq` equals `rx_flag` AND `int_en`.
- R3: While the fill bank is owned by the CPU, `in_ready` is 0 and a good packet end yields a one-cycle `hs_nak` pulse one cycle later. The stored data is unchanged.
- R4: A packet end with `pkt_bad`=1 produces no handshake pulse, discards the partial bytes and leaves the bank free. The next good packet is stored from its first byte.
- R5: `byte_cnt` is the number of unread bytes in the current bank. Each accepted pop decrements it by one, and bytes come out in arrival order.
- R6: `rd_valid` is 1 exactly while the current bank is owned and has unread bytes. When it is 0, `rd_data` is 0 and a pop changes neither `byte_cnt` nor the data.
- R7: A release request (`clr_owned`) while `rx_flag` is 1 is ignored. `bank_owned` and `byte_cnt` stay as they were.
- R8: An accepted release frees the current bank and switches to the next bank: bank 1 after bank 0 in two-bank mode, bank 0 again in one-bank mode. `rx_flag` and `bank_owned` then show the state of the new bank. If that bank is already full, both are 1 in the next cycle.
- R9: In two-bank mode, banks fill alternately starting at bank 0, so two packets are ACKed before a third is NAKed. The CPU reads them in the same order.
- R10: A bank holds at most DEPTH bytes (default 64). After DEPTH accepted bytes in one packet, `in_ready` falls, and a DEPTH-byte packet reads back complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| two_bank | input | 1 | 1 selects two banks, 0 one bank (change only in reset) |
| in_valid | input | 1 | Packet byte valid |
| in_ready | output | 1 | Fill bank can take a byte |
| in_data | input | DATA_W | Packet byte |
| pkt_end | input | 1 | End-of-packet strobe |
| pkt_bad | input | 1 | Qualifies `pkt_end`: packet aborted |
| hs_ack | output | 1 | ACK pulse, one cycle after a committed packet end |
| hs_nak | output | 1 | NAK pulse, one cycle after a refused packet end |
| int_en | input | 1 | Interrupt enable |
| irq | output | 1 | Endpoint interrupt |
| rx_flag | output | 1 | Received flag of the current bank |
| clr_flag | input | 1 | Pulse: clear `rx_flag` |
| bank_owned | output | 1 | Current bank is held by the CPU |
| clr_owned | input | 1 | Pulse: release the current bank |
| byte_cnt | output | $clog2(DEPTH+1) | Unread bytes in the current bank |
| rd_valid | output | 1 | Read-allowed status, read stream valid |
| rd_ready | input | 1 | Pop one byte |
| rd_data | output | DATA_W | Byte at the read pointer, zero when empty |

## Verification
The hardest case to reach is the immediate re-raise of the received flag. It needs two-bank mode, with a second packet committed into bank 1 while the CPU still holds bank 0. The flag must be cleared first, because a release under a set flag is refused. The directed test ACKs two packets, confirms that a third one is NAKed, drains bank 0, and then releases it. It checks in the very next cycle that the flag, the ownership and the count now describe bank 1's packet.

// File: rtl/obuf_pkg.sv
package obuf_pkg;
  typedef enum logic [1:0] {
    HS_NONE = 2'd0,
    HS_ACK  = 2'd1,
    HS_NAK  = 2'd2
  } hs_e;

  localparam int NUM_BANKS = 2;
endpackage

// File: rtl/obuf_bank.sv
module obuf_bank #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  input  logic [CNT_W-1:0]  commit_len,
  input  logic              rel,
  input  logic [CNT_W-1:0]  rd_addr,
  output logic              full,
  output logic [CNT_W-1:0]  len,
  output logic [DATA_W-1:0] rd_word
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr < CNT_W'(DEPTH))) mem[wr_addr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      len  <= '0;
    end else if (commit) begin
      full <= 1'b1;
      len  <= commit_len;
    end else if (rel) begin
      full <= 1'b0;
    end
  end

  assign rd_word = (rd_addr < CNT_W'(DEPTH)) ? mem[rd_addr[AW-1:0]] : '0;
endmodule

// File: rtl/obuf_fill_ctl.sv
module obuf_fill_ctl
  import obuf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 two_bank,
  input  logic                 in_valid,
  input  logic                 pkt_end,
  input  logic                 pkt_bad,
  input  logic [NUM_BANKS-1:0] full_vec,
  output logic                 in_ready,
  output logic                 wr_bank,
  output logic                 wr_en,
  output logic [CNT_W-1:0]     wptr,
  output logic                 commit,
  output logic [CNT_W-1:0]     commit_len,
  output hs_e                  hs
);
  logic fill_busy;

  assign fill_busy  = full_vec[wr_bank];
  assign in_ready   = !fill_busy && (wptr < CNT_W'(DEPTH));
  assign wr_en      = in_valid && in_ready;
  assign commit     = pkt_end && !pkt_bad && !fill_busy;
  assign commit_len = wptr + CNT_W'(wr_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      wr_bank <= 1'b0;
      hs      <= HS_NONE;
    end else begin
      hs <= HS_NONE;
      if (pkt_end) begin
        wptr <= '0;
        if (!pkt_bad) hs <= fill_busy ? HS_NAK : HS_ACK;
        if (commit && two_bank) wr_bank <= ~wr_bank;
      end else if (wr_en) begin
        wptr <= wptr + 1'b1;
      end
      if (!two_bank) wr_bank <= 1'b0;
    end
  end
endmodule

// File: rtl/obuf_cpu_ctl.sv
module obuf_cpu_ctl
  import obuf_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            two_bank,
  input  logic [NUM_BANKS-1:0]            full_vec,
  input  logic [NUM_BANKS-1:0][CNT_W-1:0] len_vec,
  input  logic                            commit,
  input  logic                            commit_bank,
  input  logic                            clr_flag,
  input  logic                            clr_owned,
  input  logic                            rd_ready,
  output logic                            rd_bank,
  output logic [CNT_W-1:0]                rptr,
  output logic                            rx_flag,
  output logic                            bank_owned,
  output logic                            rd_valid,
  output logic [CNT_W-1:0]                byte_cnt,
  output logic                            rel_ok
);
  logic nxt_bank;
  logic nxt_full;
  logic pop;

  assign bank_owned = full_vec[rd_bank];
  assign rd_valid   = bank_owned && (rptr < len_vec[rd_bank]);
  assign byte_cnt   = bank_owned ? (len_vec[rd_bank] - rptr) : '0;
  assign rel_ok     = clr_owned && bank_owned && !rx_flag;
  assign pop        = rd_valid && rd_ready && !rel_ok;
  assign nxt_bank   = two_bank ? ~rd_bank : 1'b0;
  assign nxt_full   = ((nxt_bank != rd_bank) && full_vec[nxt_bank]) ||
                      (commit && (commit_bank == nxt_bank));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_bank <= 1'b0;
      rptr    <= '0;
      rx_flag <= 1'b0;
    end else if (rel_ok) begin
      rd_bank <= nxt_bank;
      rptr    <= '0;
      rx_flag <= nxt_full;
    end else begin
      if (pop) rptr <= rptr + 1'b1;
      if (commit && (commit_bank == rd_bank)) rx_flag <= 1'b1;
      else if (clr_flag)                      rx_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_pingpong_buf.sv
module rx_pingpong_buf
  import obuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       two_bank,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [DATA_W-1:0]          in_data,
  input  logic                       pkt_end,
  input  logic                       pkt_bad,
  output logic                       hs_ack,
  output logic                       hs_nak,
  input  logic                       int_en,
  output logic                       irq,
  output logic                       rx_flag,
  input  logic                       clr_flag,
  output logic                       bank_owned,
  input  logic                       clr_owned,
  output logic [$clog2(DEPTH+1)-1:0] byte_cnt,
  output logic                       rd_valid,
  input  logic                       rd_ready,
  output logic [DATA_W-1:0]          rd_data
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [NUM_BANKS-1:0]            full_vec;
  logic [NUM_BANKS-1:0][CNT_W-1:0] len_vec;
  logic [NUM_BANKS-1:0][DATA_W-1:0] word_vec;
  logic                            wr_bank, wr_en, commit, rd_bank, rel_ok;
  logic [CNT_W-1:0]                wptr, commit_len, rptr;
  hs_e                             hs;

  obuf_fill_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) fill_i (
    .clk(clk), .rst_n(rst_n), .two_bank(two_bank), .in_valid(in_valid),
    .pkt_end(pkt_end), .pkt_bad(pkt_bad), .full_vec(full_vec),
    .in_ready(in_ready), .wr_bank(wr_bank), .wr_en(wr_en), .wptr(wptr),
    .commit(commit), .commit_len(commit_len), .hs(hs)
  );

  obuf_cpu_ctl #(.CNT_W(CNT_W)) cpu_i (
    .clk(clk), .rst_n(rst_n), .two_bank(two_bank), .full_vec(full_vec),
    .len_vec(len_vec), .commit(commit), .commit_bank(wr_bank),
    .clr_flag(clr_flag), .clr_owned(clr_owned), .rd_ready(rd_ready),
    .rd_bank(rd_bank), .rptr(rptr), .rx_flag(rx_flag),
    .bank_owned(bank_owned), .rd_valid(rd_valid), .byte_cnt(byte_cnt),
    .rel_ok(rel_ok)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    obuf_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) bank_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en && (wr_bank == 1'(b))), .wr_addr(wptr), .wr_data(in_data),
      .commit(commit && (wr_bank == 1'(b))), .commit_len(commit_len),
      .rel(rel_ok && (rd_bank == 1'(b))), .rd_addr(rptr),
      .full(full_vec[b]), .len(len_vec[b]), .rd_word(word_vec[b])
    );
  end

  assign rd_data = rd_valid ? word_vec[rd_bank] : '0;
  assign hs_ack  = (hs == HS_ACK);
  assign hs_nak  = (hs == HS_NAK);
  assign irq     = rx_flag && int_en;
endmodule

// File: rtl/rx_pingpong_buf_chk.sv
module rx_pingpong_buf_chk #(
  parameter int DEPTH = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       pkt_end,
  input logic                       pkt_bad,
  input logic                       hs_ack,
  input logic                       hs_nak,
  input logic                       rx_flag,
  input logic                       bank_owned,
  input logic                       clr_owned,
  input logic                       rd_valid,
  input logic                       rd_ready,
  input logic [$clog2(DEPTH+1)-1:0] byte_cnt
);
  AST_ACK_AFTER_GOOD_END: assert property (@(posedge clk) disable iff (!rst_n)
    hs_ack |-> $past(pkt_end && !pkt_bad));  // R2
  AST_NAK_AFTER_GOOD_END: assert property (@(posedge clk) disable iff (!rst_n)
    hs_nak |-> $past(pkt_end && !pkt_bad));  // R3
  AST_BAD_NO_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && pkt_bad) |=> (!hs_ack && !hs_nak));  // R4
  AST_POP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !clr_owned) |=> (byte_cnt == $past(byte_cnt) - 1'b1));  // R5
  AST_VALID_NEEDS_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (bank_owned && byte_cnt != '0));  // R6
  AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_owned && rx_flag && bank_owned) |=> (bank_owned && $stable(byte_cnt)));  // R7
  AST_FLAG_IMPLIES_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag |-> bank_owned);  // R8
endmodule

bind rx_pingpong_buf rx_pingpong_buf_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/rx_pingpong_buf_tb_top.sv
module rx_pingpong_buf_tb_top;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 64;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic two_bank = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic pkt_end = 1'b0, pkt_bad = 1'b0;
  logic hs_ack, hs_nak;
  logic int_en = 1'b1;
  logic irq, rx_flag, bank_owned, rd_valid;
  logic clr_flag = 1'b0, clr_owned = 1'b0, rd_ready = 1'b0;
  logic [CNT_W-1:0] byte_cnt;
  logic [DATA_W-1:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_pingpong_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .two_bank(two_bank), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .pkt_end(pkt_end),
    .pkt_bad(pkt_bad), .hs_ack(hs_ack), .hs_nak(hs_nak), .int_en(int_en),
    .irq(irq), .rx_flag(rx_flag), .clr_flag(clr_flag),
    .bank_owned(bank_owned), .clr_owned(clr_owned), .byte_cnt(byte_cnt),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic two);
    @(negedge clk);
    rst_n = 1'b0; two_bank = two;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Sends n bytes base+i, then a packet end; returns handshake seen next cycle.
  task automatic send_pkt(input int n, input int base, input logic bad,
                          output int acked, output int nakked, output int accepted);
    accepted = 0;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = DATA_W'(base + i);
      #1;
      if (in_ready) accepted++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    pkt_end = 1'b1; pkt_bad = bad;
    @(negedge clk);
    pkt_end = 1'b0; pkt_bad = 1'b0;
    acked = hs_ack; nakked = hs_nak;
  endtask

  task automatic pulse_flag_clear();
    clr_flag = 1'b1; @(negedge clk); clr_flag = 1'b0;
  endtask

  task automatic pulse_release();
    clr_owned = 1'b1; @(negedge clk); clr_owned = 1'b0;
  endtask

  task automatic read_check(input string req, input int n, input int base);
    for (int i = 0; i < n; i++) begin
      chk(req, "rd_data", rd_data, (base + i) & 8'hFF);
      chk(req, "byte_cnt before pop", byte_cnt, n - i);
      rd_ready = 1'b1; @(negedge clk); rd_ready = 1'b0;
    end
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk("R1", "rx_flag", rx_flag, 0);
    chk("R1", "bank_owned", bank_owned, 0);
    chk("R1", "rd_valid", rd_valid, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "byte_cnt", byte_cnt, 0);
    chk("R1", "in_ready", in_ready, 1);
    chk("R1", "hs pulses", {hs_ack, hs_nak}, 0);
  endtask

  task automatic t_single_bank();
    int a, k, acc;
    do_reset(1'b0);
    send_pkt(5, 8'h20, 1'b0, a, k, acc);
    chk("R2", "ack", a, 1);
    chk("R2", "rx_flag", rx_flag, 1);
    chk("R2", "irq", irq, 1);
    chk("R2", "byte_cnt", byte_cnt, 5);
    @(negedge clk);
    chk("R2", "ack one cycle", hs_ack, 0);
    int_en = 1'b0; #1;
    chk("R2", "irq masked", irq, 0);
    int_en = 1'b1;
    chk("R3", "in_ready owned", in_ready, 0);
    send_pkt(3, 8'h90, 1'b0, a, k, acc);
    chk("R3", "nak", k, 1);
    chk("R3", "no ack", a, 0);
    chk("R3", "accepted", acc, 0);
    chk("R3", "byte_cnt kept", byte_cnt, 5);
    pulse_release();
    chk("R7", "owned kept", bank_owned, 1);
    chk("R7", "byte_cnt kept", byte_cnt, 5);
    pulse_flag_clear();
    chk("R2", "flag cleared", rx_flag, 0);
    chk("R2", "irq cleared", irq, 0);
    read_check("R5", 5, 8'h20);
    chk("R6", "rd_valid empty", rd_valid, 0);
    chk("R6", "rd_data empty", rd_data, 0);
    rd_ready = 1'b1; @(negedge clk); rd_ready = 1'b0;
    chk("R6", "byte_cnt after empty pop", byte_cnt, 0);
    chk("R6", "owned after empty pop", bank_owned, 1);
    pulse_release();
    chk("R8", "owned freed", bank_owned, 0);
    chk("R8", "flag single", rx_flag, 0);
    chk("R8", "in_ready freed", in_ready, 1);
    send_pkt(3, 8'h30, 1'b0, a, k, acc);
    chk("R8", "ack after free", a, 1);
    chk("R8", "byte_cnt", byte_cnt, 3);
    chk("R8", "rd_data", rd_data, 8'h30);
  endtask

  task automatic t_abort();
    int a, k, acc;
    do_reset(1'b0);
    send_pkt(7, 8'hA0, 1'b1, a, k, acc);
    chk("R4", "handshake", a + k, 0);
    chk("R4", "rx_flag", rx_flag, 0);
    chk("R4", "owned", bank_owned, 0);
    chk("R4", "in_ready", in_ready, 1);
    send_pkt(2, 8'h55, 1'b0, a, k, acc);
    chk("R4", "ack", a, 1);
    chk("R4", "byte_cnt", byte_cnt, 2);
    chk("R4", "first byte", rd_data, 8'h55);
  endtask

  task automatic t_two_bank();
    int a, k, acc;
    do_reset(1'b1);
    send_pkt(4, 8'h10, 1'b0, a, k, acc);
    chk("R9", "ack A", a, 1);
    send_pkt(6, 8'h40, 1'b0, a, k, acc);
    chk("R9", "ack B", a, 1);
    chk("R9", "cnt still A", byte_cnt, 4);
    chk("R9", "in_ready both full", in_ready, 0);
    send_pkt(2, 8'hEE, 1'b0, a, k, acc);
    chk("R9", "nak C", k, 1);
    pulse_flag_clear();
    read_check("R9", 4, 8'h10);
    pulse_release();
    chk("R8", "flag re-raised", rx_flag, 1);
    chk("R8", "owned new bank", bank_owned, 1);
    chk("R8", "byte_cnt new bank", byte_cnt, 6);
    chk("R8", "irq re-raised", irq, 1);
    chk("R9", "bank 0 free", in_ready, 1);
    pulse_flag_clear();
    read_check("R9", 6, 8'h40);
    pulse_release();
    chk("R8", "flag after both", rx_flag, 0);
    chk("R8", "owned after both", bank_owned, 0);
    send_pkt(2, 8'h77, 1'b0, a, k, acc);
    chk("R9", "ack D", a, 1);
    chk("R9", "D readable", rd_data, 8'h77);
    chk("R9", "D cnt", byte_cnt, 2);
  endtask

  task automatic t_capacity();
    int a, k, acc;
    do_reset(1'b0);
    send_pkt(DEPTH + 6, 0, 1'b0, a, k, acc);
    chk("R10", "accepted bytes", acc, DEPTH);
    chk("R10", "ack", a, 1);
    chk("R10", "byte_cnt", byte_cnt, DEPTH);
    pulse_flag_clear();
    read_check("R10", DEPTH, 0);
    chk("R10", "drained", rd_valid, 0);
  endtask

  initial begin
    t_reset();
    t_single_bank();
    t_abort();
    t_two_bank();
    t_capacity();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule